// File: doc/BRIEF.md
# Digital Stochastic Binary Neuron Array

This block is a small array of stochastic binary units that are coupled through a digital synapse. Each unit keeps one binary state. When a unit updates, the synapse forms its input field from the bias of that unit and the signed weights to every other unit, where each other unit counts as +1 when its stored bit is 1 and as -1 when its stored bit is 0. A bounded, monotone, tanh-like activation turns this field into an unsigned 8-bit threshold. The unit's new state is 1 when that threshold is strictly greater than an 8-bit random number taken from the unit's own linear feedback shift register. The result is a sample whose bias follows the input, not a fixed function of it.

Units update one at a time in round-robin order. A full sweep visits every unit once, and after each sweep the array presents the sampled state vector together with a one-cycle valid pulse. A host loads weights and biases through a simple write port. Writes go into a staging copy. The working copy takes the staged values only at a sweep boundary, so each sweep runs on one consistent parameter set.

Top module: `pbit_array`

## Requirements
- R1: After reset, `sample_valid` is 0, `sample_state` is 0, every stored unit state is 0, and all staged and working weights and biases are 0.
- R2: The field of unit i is h[i] plus, for each j other than i, +W[i][j] when state bit j is 1 and -W[i][j] when it is 0. Weights and biases are signed 8-bit two's complement. The field is clamped to the range ±2047.
- R3: The self weight W[i][i] has no effect on any sample, whatever value is written to it.
- R4: The threshold is computed from the magnitude a = |field|. y = a when a < 64; otherwise y = min(64 + ((a - 64) >> 1), 127). The threshold is 128 + y for a non-negative field and 128 - y for a negative field, so a zero field gives 128.
- R5: Unit k's random value is bits [7:0] of a 16-bit register that shifts left every clock cycle. The new bit 0 is the XOR of old bits 15, 13, 12 and 10. At reset the register is loaded with 16'hACE1 XOR the low 16 bits of (k * 16'h3C5B). The new state is 1 exactly when threshold > random value.
- R6: Exactly one unit updates per clock cycle, in the order 0, 1, 2, 3, 0, and so on. Each update uses the most recent states of all the other units.
- R7: A write with `wr_bias` = 1 sets h[`wr_row`]. A write with `wr_bias` = 0 sets W[`wr_row`][`wr_col`]. Writes reach the working copy only at the edge that ends a sweep, and a write accepted at that same edge is included.
- R8: `sample_valid` pulses high for one cycle after the edge at which unit 3 updates. At that edge `sample_state` (bit k = unit k) takes the complete vector and holds it until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_bias | input | 1 | 1 selects a bias, 0 selects a weight |
| wr_row | input | 2 | Target unit i |
| wr_col | input | 2 | Source unit j (weights only) |
| wr_data | input | 8 | Signed value to write |
| sample_valid | output | 1 | One-cycle pulse after each complete sweep |
| sample_state | output | 4 | Latest complete state vector |

## Verification
A host write can land in the same cycle that the last unit of a sweep updates. That write has to enter the working copy at once, while a write one cycle earlier or later must not move the sweep boundary. The bench forces this collision on purpose by aiming a directed write at the final update slot. It also sends random writes across every slot of the sweep. A cycle-accurate reference model of the staging and working copies judges every sampled vector, so a write that is taken a sweep too early or too late shows up as a diverging sample.

// File: rtl/pbit_pkg.sv
package pbit_pkg;

    localparam int unsigned LFSR_BITS   = 16;
    localparam logic [15:0] SEED_ORIGIN = 16'hACE1;
    localparam logic [31:0] SEED_STRIDE = 32'h0000_3C5B;
    localparam logic [15:0] TAP_MASK    = 16'hB400;

    function automatic logic [15:0] unit_seed(input int unsigned k);
        logic [31:0] prod;
        prod = k * SEED_STRIDE;
        return SEED_ORIGIN ^ prod[15:0];
    endfunction

endpackage

// File: rtl/pbit_lfsr.sv
module pbit_lfsr #(
    parameter int unsigned          LFSR_W = 16,
    parameter int unsigned          RND_W  = 8,
    parameter logic [LFSR_W-1:0]    SEED   = 16'hACE1,
    parameter logic [LFSR_W-1:0]    TAPS   = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q[RND_W-1:0];

    // R5: a maximal-length generator never enters the all-zero lock state
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r5_lfsr_nonzero: assert (lfsr_q != '0)
                else $error("generator reached zero");
        end
    end
endmodule

// File: rtl/pbit_synapse.sv
module pbit_synapse #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned W_W     = 8,
    parameter int unsigned SUM_W   = 12,
    localparam int unsigned IDX_W  = $clog2(N_UNITS),
    localparam int unsigned ACC_W  = SUM_W + W_W
) (
    input  logic [N_UNITS-1:0]          state_i,
    input  logic [N_UNITS-1:0][W_W-1:0] w_row_i,
    input  logic [W_W-1:0]              bias_i,
    input  logic [IDX_W-1:0]            self_i,
    output logic signed [SUM_W-1:0]     sum_o
);
    localparam logic signed [ACC_W-1:0] LIMIT = ACC_W'((1 << (SUM_W - 1)) - 1);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] term;

    always_comb begin
        acc  = ACC_W'($signed(bias_i));
        term = '0;
        for (int j = 0; j < N_UNITS; j++) begin
            term = ACC_W'($signed(w_row_i[j]));
            if (IDX_W'(j) != self_i) begin
                if (state_i[j]) acc = acc + term;
                else            acc = acc - term;
            end
        end
        if (acc > LIMIT)       sum_o = LIMIT[SUM_W-1:0];
        else if (acc < -LIMIT) sum_o = (-LIMIT);
        else                   sum_o = acc[SUM_W-1:0];
    end

    // R2: the clamped field stays inside the symmetric range
    always_comb begin
        a_r2_field_range: assert (sum_o != {1'b1, {(SUM_W-1){1'b0}}})
            else $error("field left the symmetric range");
    end
endmodule

// File: rtl/pbit_activation.sv
module pbit_activation #(
    parameter int unsigned SUM_W = 12,
    parameter int unsigned THR_W = 8,
    localparam int unsigned HALF = 1 << (THR_W - 1),
    localparam int unsigned KNEE = HALF / 2
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [THR_W-1:0]        thr_o
);
    logic [SUM_W-1:0] mag;
    logic [SUM_W:0]   bent;
    logic [THR_W-1:0] y;

    always_comb begin
        mag  = sum_i[SUM_W-1] ? SUM_W'(-sum_i) : SUM_W'(sum_i);
        bent = '0;
        if (mag < SUM_W'(KNEE)) begin
            y = THR_W'(mag);
        end else begin
            bent = (SUM_W+1)'(KNEE) + (((SUM_W+1)'(mag) - (SUM_W+1)'(KNEE)) >> 1);
            y    = (bent > (SUM_W+1)'(HALF - 1)) ? THR_W'(HALF - 1) : THR_W'(bent);
        end
        thr_o = sum_i[SUM_W-1] ? (THR_W'(HALF) - y) : (THR_W'(HALF) + y);
    end

    // R4: zero field sits at the midpoint, and the sign picks the half
    always_comb begin
        if (sum_i == '0) begin
            a_r4_zero_mid: assert (thr_o == THR_W'(HALF))
                else $error("zero field off midpoint");
        end
        a_r4_sign_half: assert (sum_i[SUM_W-1] == (thr_o < THR_W'(HALF)))
            else $error("threshold on wrong side of midpoint");
    end
endmodule

// File: rtl/pbit_array.sv
module pbit_array #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned W_W     = 8,
    parameter int unsigned SUM_W   = 12,
    parameter int unsigned RND_W   = 8,
    localparam int unsigned IDX_W  = $clog2(N_UNITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_bias,
    input  logic [IDX_W-1:0]   wr_row,
    input  logic [IDX_W-1:0]   wr_col,
    input  logic [W_W-1:0]     wr_data,
    output logic               sample_valid,
    output logic [N_UNITS-1:0] sample_state
);
    import pbit_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_UNITS - 1);

    typedef struct packed {
        logic [N_UNITS-1:0][N_UNITS-1:0][W_W-1:0] stage_w;
        logic [N_UNITS-1:0][W_W-1:0]              stage_h;
        logic [N_UNITS-1:0][N_UNITS-1:0][W_W-1:0] work_w;
        logic [N_UNITS-1:0][W_W-1:0]              work_h;
        logic [N_UNITS-1:0]                       units;
        logic [IDX_W-1:0]                         turn;
        logic                                     vld;
        logic [N_UNITS-1:0]                       snap;
    } arr_t;

    arr_t s_d, s_q;

    logic [N_UNITS-1:0][RND_W-1:0] rnd_all;
    logic [RND_W-1:0]              rnd_sel;
    logic signed [SUM_W-1:0]       field;
    logic [RND_W-1:0]              thr;
    logic                          decide;

    for (genvar k = 0; k < N_UNITS; k++) begin : g_src
        pbit_lfsr #(
            .LFSR_W (LFSR_BITS),
            .RND_W  (RND_W),
            .SEED   (unit_seed(k)),
            .TAPS   (TAP_MASK)
        ) i_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .rnd_o (rnd_all[k])
        );
    end

    pbit_synapse #(
        .N_UNITS (N_UNITS),
        .W_W     (W_W),
        .SUM_W   (SUM_W)
    ) i_syn (
        .state_i (s_q.units),
        .w_row_i (s_q.work_w[s_q.turn]),
        .bias_i  (s_q.work_h[s_q.turn]),
        .self_i  (s_q.turn),
        .sum_o   (field)
    );

    pbit_activation #(
        .SUM_W (SUM_W),
        .THR_W (RND_W)
    ) i_act (
        .sum_i (field),
        .thr_o (thr)
    );

    assign rnd_sel = rnd_all[s_q.turn];
    assign decide  = (thr > rnd_sel);

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (wr_en) begin
            if (wr_bias) s_d.stage_h[wr_row]         = wr_data;
            else         s_d.stage_w[wr_row][wr_col] = wr_data;
        end
        s_d.units[s_q.turn] = decide;
        if (s_q.turn == LAST) begin
            s_d.turn   = '0;
            s_d.vld    = 1'b1;
            s_d.snap   = s_d.units;
            s_d.work_w = s_d.stage_w;
            s_d.work_h = s_d.stage_h;
        end else begin
            s_d.turn = s_q.turn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sample_valid = s_q.vld;
    assign sample_state = s_q.snap;

    // R8: valid is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R8: the reported vector only moves together with a pulse
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_state));

    // R6: at most one unit state changes per edge
    a_r6_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.units ^ $past(s_q.units)) <= 1);

    // R7: working parameters change only at a sweep boundary
    a_r7_work_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.turn != '0) |-> ($stable(s_q.work_w) && $stable(s_q.work_h)));
endmodule

// File: tb/test_pbit_array.sv
module test_pbit_array;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bias = 1'b0;
    logic [1:0] wr_row = '0;
    logic [1:0] wr_col = '0;
    logic [7:0] wr_data = '0;
    logic       sample_valid;
    logic [3:0] sample_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pbit_array i_pbit_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_bias      (wr_bias),
        .wr_row       (wr_row),
        .wr_col       (wr_col),
        .wr_data      (wr_data),
        .sample_valid (sample_valid),
        .sample_state (sample_state)
    );

    // reference model
    int        sw [N][N];
    int        sh [N];
    int        aw [N][N];
    int        ah [N];
    bit        m [N];
    logic [15:0] lf [N];
    int        turn;
    bit        exp_valid;
    logic [3:0] exp_state;

    function automatic int act(int f);
        int a, y;
        a = (f < 0) ? -f : f;
        if (a < 64) y = a;
        else begin
            y = 64 + ((a - 64) >> 1);
            if (y > 127) y = 127;
        end
        return (f < 0) ? 128 - y : 128 + y;
    endfunction

    function automatic logic [15:0] seed(int k);
        logic [31:0] p;
        p = k * 32'h3C5B;
        return 16'hACE1 ^ p[15:0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                sw[i][j] = 0;
                aw[i][j] = 0;
            end
            sh[i] = 0; ah[i] = 0; m[i] = 0; lf[i] = seed(i);
        end
        turn = 0; exp_valid = 0; exp_state = '0;
    endtask

    task automatic model_step(bit we, bit b, int r, int c, int v);
        int f, t;
        if (we) begin
            if (b) sh[r] = v;
            else   sw[r][c] = v;
        end
        f = ah[turn];
        for (int j = 0; j < N; j++)
            if (j != turn) f += m[j] ? aw[turn][j] : -aw[turn][j];
        if (f > 2047) f = 2047;
        if (f < -2047) f = -2047;
        t = act(f);
        m[turn] = (t > int'(lf[turn][7:0]));
        exp_valid = 0;
        if (turn == N - 1) begin
            exp_valid = 1;
            for (int k = 0; k < N; k++) exp_state[k] = m[k];
            aw = sw; ah = sh;
            turn = 0;
        end else turn++;
        for (int k = 0; k < N; k++)
            lf[k] = {lf[k][14:0], lf[k][15] ^ lf[k][13] ^ lf[k][12] ^ lf[k][10]};
    endtask

    task automatic check(bit ok, string req, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // one clock: drive at negedge, step model, compare at following negedge
    task automatic cycle(bit we, bit b, int r, int c, int v, string tag);
        wr_en = we; wr_bias = b; wr_row = 2'(r); wr_col = 2'(c); wr_data = 8'(v);
        model_step(we, b, r, c, v);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(sample_valid == exp_valid, "R8 valid", sample_valid, exp_valid);
        if (exp_valid)
            check(sample_state == exp_state, tag, sample_state, exp_state);
        else
            check(sample_state == exp_state, "R8 hold", sample_state, exp_state);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sample_valid == 1'b0, "R1 valid", sample_valid, 0);
        check(sample_state == 4'h0, "R1 state", sample_state, 0);
        rst_n = 1'b1;

        // zero parameters: pure midpoint threshold against generators (R4 R5 R6)
        idle(4 * 30, "R4 R5 R6 zero-field");

        // strong ferromagnetic coupling and biases (R2)
        for (int i = 0; i < N; i++) begin
            cycle(1, 1, i, 0, 100, "R2 R7 setup");
            for (int j = 0; j < N; j++)
                if (j != i) cycle(1, 0, i, j, 127, "R2 R7 setup");
        end
        idle(4 * 20, "R2 coupled");

        // self weights loaded with extremes must not matter (R3)
        for (int i = 0; i < N; i++) cycle(1, 0, i, i, -128, "R3 setup");
        idle(4 * 20, "R3 self weight ignored");
        for (int i = 0; i < N; i++) cycle(1, 0, i, i, 127, "R3 setup");
        idle(4 * 20, "R3 self weight ignored");

        // write landing exactly on the last update slot of a sweep (R7)
        while (turn != N - 1) cycle(0, 0, 0, 0, 0, "R7 align");
        cycle(1, 1, 0, 0, -128, "R7 boundary write");
        idle(4 * 10, "R7 after boundary");
        while (turn != 0) cycle(0, 0, 0, 0, 0, "R7 align");
        cycle(1, 1, 1, 0, -120, "R7 early write");
        idle(4 * 10, "R7 after early");

        // antiferromagnetic ring (R2 R6)
        for (int i = 0; i < N; i++) begin
            cycle(1, 1, i, 0, 0, "R2 setup");
            for (int j = 0; j < N; j++)
                if (j != i) cycle(1, 0, i, j, -90, "R2 setup");
        end
        idle(4 * 20, "R2 R6 anti");

        // constrained random mix (R2 R3 R4 R5 R6 R7)
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0)
                cycle(1, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                      $urandom_range(0, 255) - 128, "R2 R4 R5 R6 R7 random");
            else
                cycle(0, 0, 0, 0, 0, "R2 R4 R5 R6 R7 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule